// File: doc/BRIEF.md
# Speculative Reorder Buffer with Misprediction Flush

This block keeps the program order of instructions in an out-of-order core. Each instruction the issue stage sends in takes one slot in a circular buffer. The slot records three things: whether the instruction writes a register, which register that is, and the tag of the station that will compute its result. Execution results come back on a broadcast carrying a tag. The one live slot holding that tag captures the value and is marked done. The oldest slot retires as soon as it is done, and a retiring slot that names a register writes its value into the committed register copy. Because retirement follows issue order, results that finish out of order still reach that copy in program order.

Branch slots carry the predicted direction, and their broadcast delivers the actual direction. A misprediction is acted on only once the branch is the oldest slot. In that cycle the whole buffer is emptied and a one-cycle restore pulse is raised, so the issue-side register state can be reloaded from the committed copy. The committed copy can be read back through a combinational read port.

Top module: `specRob`

## Requirements
- R1: After reset the buffer is empty, issueReady is 1, commitValid and restorePulse are 0, and every committed register reads 0.
- R2: An instruction is accepted on a rising edge with issueValid=1 and issueReady=1. The buffer holds 8 entries, and issueReady is 0 while all 8 are live.
- R3: A broadcast (wbValid=1) whose wbTag equals the tag of a live, not-yet-done entry stores wbValue and wbTaken in that entry and marks it done. A done oldest entry shows commitValid=1 in the cycle after the broadcast edge, with commitValue equal to the broadcast value.
- R4: Entries retire strictly in issue order, at most one per cycle. An entry that completes before an older one does not retire until the older one has.
- R5: On the edge where a retiring entry has commitHasDst=1, its value is written to committed register commitDst. That value is readable on rdData from then on.
- R6: An entry issued with issueHasDst=0 (store or branch) retires with commitHasDst=0 and leaves every committed register unchanged.
- R7: A branch entry (issueIsBranch=1) whose wbTaken differs from issuePredTaken raises restorePulse for exactly one cycle once it is the oldest done entry. commitValid is 0 in that cycle. On that edge every entry is discarded and no younger entry updates a committed register.
- R8: A branch whose wbTaken equals issuePredTaken retires like a store: commitValid=1, commitHasDst=0, restorePulse=0.
- R9: In the restore cycle issueReady is 0, so an instruction offered in that cycle is not accepted. The buffer is empty after that edge.
- R10: A broadcast whose tag matches no live, not-done entry has no effect. For example, a tag that belonged to an entry discarded by a flush completes nothing.
- R11: When two entries write the same register, the committed register ends up holding the younger entry's value, whatever order the broadcasts arrive in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | Issue stage offers an instruction |
| issueHasDst | input | 1 | Instruction writes a register |
| issueDst | input | 3 | Destination register index |
| issueTag | input | 4 | Tag of the producing station |
| issueIsBranch | input | 1 | Instruction is a conditional branch |
| issuePredTaken | input | 1 | Predicted branch direction |
| issueReady | output | 1 | Buffer can accept an instruction this cycle |
| wbValid | input | 1 | Result broadcast present |
| wbTag | input | 4 | Tag of the broadcasting station |
| wbValue | input | 16 | Result value |
| wbTaken | input | 1 | Actual direction, for branch results |
| commitValid | output | 1 | Oldest entry retires this cycle |
| commitHasDst | output | 1 | Retiring entry writes a register |
| commitDst | output | 3 | Register written by the retiring entry |
| commitValue | output | 16 | Value written by the retiring entry |
| restorePulse | output | 1 | Misprediction at the oldest entry; reload issue-side registers |
| rdAddr | input | 3 | Committed register read address |
| rdData | output | 16 | Committed register read data |

## Verification
The assertions assume that the tag of every new instruction differs from the tags of all live entries. They also assume that any broadcast matches at most one live, not-yet-done entry. The stimulus keeps within this by drawing each new tag from those its model shows as free, and by aiming random broadcasts only at pending model entries. Stale tags are sent on purpose only after a flush, when no live entry carries them. Random branch outcomes agree with the prediction most of the time, so long runs of retirement occur between flushes.

// File: rtl/robPkg.sv
package robPkg;
  parameter int ROB_DEPTH = 8;
  parameter int ROB_TAG_W = 4;
  parameter int ROB_REG_W = 3;
  parameter int ROB_DATA_W = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic alloc;
    logic commit;
    logic flush;
  } robStrobeT;
endpackage

// File: rtl/robCtrl.sv
module robCtrl
  import robPkg::*;
#(
  parameter int DEPTH = ROB_DEPTH,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             headComplete,
  input  logic             headMispredict,
  output robStrobeT        strobe,
  output logic [PTR_W-1:0] allocIdx,
  output logic [PTR_W-1:0] headIdx,
  output logic             issueReady
);
  // Extra wrap bit on each pointer separates full from empty
  logic [PTR_W:0] headQ, tailQ, occ;
  logic empty, full;

  always_comb begin
    occ   = tailQ - headQ;
    empty = (headQ == tailQ);
    full  = (headQ[PTR_W] != tailQ[PTR_W]) &&
            (headQ[PTR_W-1:0] == tailQ[PTR_W-1:0]);
    strobe.flush  = !empty && headComplete && headMispredict;
    strobe.commit = !empty && headComplete && !headMispredict;
    issueReady    = !full && !strobe.flush;
    strobe.alloc  = issueValid && issueReady;
    allocIdx = tailQ[PTR_W-1:0];
    headIdx  = headQ[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
    end else if (strobe.flush) begin
      headQ <= '0;
      tailQ <= '0;
    end else begin
      if (strobe.commit) headQ <= headQ + 1'b1;
      if (strobe.alloc)  tailQ <= tailQ + 1'b1;
    end
  end

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occ <= DEPTH);
  // R4
  occ_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.flush |=> (occ <= $past(occ) + 1'b1) && (occ + 1'b1 >= $past(occ)));
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> empty);
  // R7
  restore_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> !strobe.flush);
endmodule

// File: rtl/robData.sv
module robData
  import robPkg::*;
#(
  parameter int DEPTH  = ROB_DEPTH,
  parameter int TAG_W  = ROB_TAG_W,
  parameter int REG_W  = ROB_REG_W,
  parameter int DATA_W = ROB_DATA_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int NREGS = 1 << REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobeT         strobe,
  input  logic [PTR_W-1:0]  allocIdx,
  input  logic [PTR_W-1:0]  headIdx,
  input  logic              issueHasDst,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic              issueIsBranch,
  input  logic              issuePredTaken,
  input  logic              wbValid,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbValue,
  input  logic              wbTaken,
  input  logic [REG_W-1:0]  rdAddr,
  output logic              headComplete,
  output logic              headMispredict,
  output logic              headHasDst,
  output logic [REG_W-1:0]  headDst,
  output logic [DATA_W-1:0] headValue,
  output logic [DATA_W-1:0] rdData
);
  logic [DEPTH-1:0]  validQ, doneQ, hasDstQ, isBrQ, predQ, actQ;
  logic [REG_W-1:0]  dstQ [DEPTH];
  logic [TAG_W-1:0]  tagQ [DEPTH];
  logic [DATA_W-1:0] valQ [DEPTH];
  logic [DATA_W-1:0] cregQ [NREGS];
  logic [DEPTH-1:0]  wbHit, allocHit;

  // Tag match across every live slot
  for (genvar i = 0; i < DEPTH; i++) begin : gMatch
    assign wbHit[i]    = wbValid && validQ[i] && !doneQ[i] && (tagQ[i] == wbTag);
    assign allocHit[i] = validQ[i] && (tagQ[i] == issueTag);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      doneQ  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.flush) begin
          validQ[i] <= 1'b0;
          doneQ[i]  <= 1'b0;
        end else if (strobe.alloc && allocIdx == PTR_W'(i)) begin
          validQ[i] <= 1'b1;
          doneQ[i]  <= 1'b0;
        end else begin
          if (strobe.commit && headIdx == PTR_W'(i)) validQ[i] <= 1'b0;
          if (wbHit[i]) doneQ[i] <= 1'b1;
        end
      end
    end
  end

  // Payload needs no reset: it is read only while validQ is set
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (strobe.alloc && allocIdx == PTR_W'(i)) begin
        hasDstQ[i] <= issueHasDst;
        dstQ[i]    <= issueDst;
        tagQ[i]    <= issueTag;
        isBrQ[i]   <= issueIsBranch;
        predQ[i]   <= issuePredTaken;
      end
      if (wbHit[i]) begin
        valQ[i] <= wbValue;
        actQ[i] <= wbTaken;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NREGS; r++) cregQ[r] <= '0;
    end else if (strobe.commit && headHasDst) begin
      cregQ[headDst] <= headValue;
    end
  end

  always_comb begin
    headComplete   = validQ[headIdx] && doneQ[headIdx];
    headMispredict = isBrQ[headIdx] && (predQ[headIdx] != actQ[headIdx]);
    headHasDst     = hasDstQ[headIdx];
    headDst        = dstQ[headIdx];
    headValue      = valQ[headIdx];
    rdData         = cregQ[rdAddr];
  end

  // R2
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> (allocHit == '0));
  // R3
  wb_single_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wbHit));
  // R5
  commit_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && headHasDst) |=> cregQ[$past(headDst)] == $past(headValue));
  // R4
  head_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !strobe.alloc) |=> !validQ[$past(headIdx)]);
endmodule

// File: rtl/specRob.sv
module specRob
  import robPkg::*;
#(
  parameter int DEPTH  = ROB_DEPTH,
  parameter int TAG_W  = ROB_TAG_W,
  parameter int REG_W  = ROB_REG_W,
  parameter int DATA_W = ROB_DATA_W,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              issueHasDst,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic              issueIsBranch,
  input  logic              issuePredTaken,
  output logic              issueReady,
  input  logic              wbValid,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbValue,
  input  logic              wbTaken,
  output logic              commitValid,
  output logic              commitHasDst,
  output logic [REG_W-1:0]  commitDst,
  output logic [DATA_W-1:0] commitValue,
  output logic              restorePulse,
  input  logic [REG_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData
);
  robStrobeT strobe;
  logic [PTR_W-1:0] allocIdx, headIdx;
  logic headComplete, headMispredict;

  robCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid),
    .headComplete(headComplete), .headMispredict(headMispredict),
    .strobe(strobe), .allocIdx(allocIdx), .headIdx(headIdx),
    .issueReady(issueReady)
  );

  robData #(.DEPTH(DEPTH), .TAG_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .allocIdx(allocIdx), .headIdx(headIdx),
    .issueHasDst(issueHasDst), .issueDst(issueDst), .issueTag(issueTag),
    .issueIsBranch(issueIsBranch), .issuePredTaken(issuePredTaken),
    .wbValid(wbValid), .wbTag(wbTag), .wbValue(wbValue), .wbTaken(wbTaken),
    .rdAddr(rdAddr),
    .headComplete(headComplete), .headMispredict(headMispredict),
    .headHasDst(headHasDst0), .headDst(commitDst), .headValue(commitValue),
    .rdData(rdData)
  );

  logic headHasDst0;
  assign commitValid  = strobe.commit;
  assign commitHasDst = headHasDst0;
  assign restorePulse = strobe.flush;
endmodule

// File: tb/sim_specRob.sv
`timescale 1ns/1ps
module sim_specRob;
  import robPkg::*;
  localparam int DEPTH = ROB_DEPTH;
  localparam int TAG_W = ROB_TAG_W;
  localparam int REG_W = ROB_REG_W;
  localparam int DATA_W = ROB_DATA_W;
  localparam int NREGS = 1 << REG_W;
  localparam int NTAGS = 1 << TAG_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic issueValid, issueHasDst, issueIsBranch, issuePredTaken, issueReady;
  logic [REG_W-1:0] issueDst, commitDst, rdAddr;
  logic [TAG_W-1:0] issueTag, wbTag;
  logic wbValid, wbTaken, commitValid, commitHasDst, restorePulse;
  logic [DATA_W-1:0] wbValue, commitValue, rdData;

  specRob u0 (.*);

  typedef struct {
    logic hasDst; logic [REG_W-1:0] dst; logic [TAG_W-1:0] tag;
    logic [DATA_W-1:0] val; logic done; logic isBr; logic pred; logic act;
  } entT;
  entT mq[$];
  logic [DATA_W-1:0] expReg [NREGS];
  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit mFlush();
    return mq.size() > 0 && mq[0].done && mq[0].isBr && (mq[0].pred != mq[0].act);
  endfunction
  function automatic bit mCommit();
    return mq.size() > 0 && mq[0].done && !mFlush();
  endfunction
  function automatic bit mReady();
    return mq.size() < DEPTH && !mFlush();
  endfunction
  function automatic bit tagLive(logic [TAG_W-1:0] t);
    foreach (mq[k]) if (mq[k].tag == t) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic setIssue(bit hasDst, int dst, int tag, bit isBr, bit pred);
    issueValid = 1'b1; issueHasDst = hasDst; issueDst = REG_W'(dst);
    issueTag = TAG_W'(tag); issueIsBranch = isBr; issuePredTaken = pred;
  endtask
  task automatic setWb(int tag, int val, bit taken);
    wbValid = 1'b1; wbTag = TAG_W'(tag); wbValue = DATA_W'(val); wbTaken = taken;
  endtask

  // Check outputs, clock once, update model; called and returns at negedge
  task automatic step();
    bit fl, cm, rd;
    entT e;
    fl = mFlush(); cm = mCommit(); rd = mReady();
    chk("R2", "issueReady", issueReady, rd);
    chk("R4", "commitValid", commitValid, cm);
    chk("R7", "restorePulse", restorePulse, fl);
    if (cm) begin
      chk("R6", "commitHasDst", commitHasDst, mq[0].hasDst);
      if (mq[0].hasDst) begin
        chk("R4", "commitDst", commitDst, mq[0].dst);
        chk("R3", "commitValue", commitValue, mq[0].val);
      end
    end
    @(posedge clk);
    if (fl) mq.delete();
    else begin
      if (cm) begin
        if (mq[0].hasDst) expReg[mq[0].dst] = mq[0].val;
        void'(mq.pop_front());
      end
      if (wbValid)
        foreach (mq[k])
          if (mq[k].tag == wbTag && !mq[k].done) begin
            mq[k].val = wbValue; mq[k].act = wbTaken; mq[k].done = 1'b1;
          end
      if (issueValid && rd) begin
        e.hasDst = issueHasDst; e.dst = issueDst; e.tag = issueTag; e.val = '0;
        e.done = 1'b0; e.isBr = issueIsBranch; e.pred = issuePredTaken; e.act = 1'b0;
        mq.push_back(e);
      end
    end
    @(negedge clk);
    issueValid = 1'b0; wbValid = 1'b0;
  endtask

  task automatic chkRegs(string req);
    for (int r = 0; r < NREGS; r++) begin
      rdAddr = REG_W'(r); #1;
      chk(req, "committed register", rdData, expReg[r]);
    end
  endtask

  initial begin
    void'($urandom(32'd7331));
    rstN = 1'b0; issueValid = 0; issueHasDst = 0; issueDst = '0; issueTag = '0;
    issueIsBranch = 0; issuePredTaken = 0; wbValid = 0; wbTag = '0; wbValue = '0;
    wbTaken = 0; rdAddr = '0;
    for (int r = 0; r < NREGS; r++) expReg[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "issueReady", issueReady, 1);
    chk("R1", "commitValid", commitValid, 0);
    chk("R1", "restorePulse", restorePulse, 0);
    chkRegs("R1");

    // R2 fill to capacity, ninth offer refused; R4 out-of-order completion
    for (int i = 0; i < 9; i++) begin setIssue(1, i % NREGS, i, 0, 0); step(); end
    chk("R2", "issueReady when full", issueReady, 0);
    for (int i = 7; i >= 1; i--) begin setWb(i, 100 + i, 0); step(); end
    chk("R4", "no retire before oldest", commitValid, 0);
    setWb(0, 100, 0); step();
    repeat (10) step();
    chkRegs("R5");

    // R11 same destination, younger result arrives first
    setIssue(1, 3, 1, 0, 0); step();
    setIssue(1, 3, 2, 0, 0); step();
    setWb(2, 16'h222, 0); step();
    setWb(1, 16'h111, 0); step();
    repeat (3) step();
    rdAddr = 3; #1; chk("R11", "younger value wins", rdData, 16'h222);

    // R6 store leaves registers untouched
    setIssue(0, 5, 3, 0, 0); step();
    setWb(3, 16'hBEEF, 0); step();
    chk("R6", "store commitHasDst", commitHasDst, 0);
    repeat (2) step();
    chkRegs("R6");

    // R8 correctly predicted branch
    setIssue(0, 0, 3, 1, 1); step();
    setWb(3, 0, 1); step();
    chk("R8", "commitValid", commitValid, 1);
    chk("R8", "restorePulse", restorePulse, 0);
    step();

    // R7/R9 mispredicted branch with completed younger entries
    setIssue(0, 0, 4, 1, 0); step();
    setIssue(1, 1, 5, 0, 0); step();
    setIssue(1, 2, 6, 0, 0); step();
    setWb(5, 16'h0A5A, 0); step();
    setWb(6, 16'h0B5B, 0); step();
    setWb(4, 0, 1); step();
    chk("R7", "restorePulse at head", restorePulse, 1);
    chk("R9", "issueReady during flush", issueReady, 0);
    setIssue(1, 4, 7, 0, 0); step();
    chk("R9", "empty after flush", commitValid, 0);
    chk("R9", "issueReady after flush", issueReady, 1);
    chkRegs("R7");

    // R10 stale broadcast
    setIssue(1, 6, 9, 0, 0); step();
    setWb(6, 16'h7777, 0); step();
    setWb(7, 16'h7777, 0); step();
    chk("R10", "stale tag completes nothing", commitValid, 0);
    setWb(9, 16'h0999, 0); step();
    chk("R10", "live tag completes", commitValid, 1);
    step();
    chkRegs("R10");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(99) < 60) begin
        int t; bit br;
        t = $urandom_range(NTAGS - 1);
        while (tagLive(TAG_W'(t))) t = (t + 1) % NTAGS;
        br = ($urandom_range(99) < 20);
        setIssue(!br && ($urandom_range(99) < 85), $urandom_range(NREGS - 1), t, br,
                 $urandom_range(1));
      end
      if ($urandom_range(99) < 50 && mq.size() > 0) begin
        int k;
        k = $urandom_range(mq.size() - 1);
        if (!mq[k].done)
          setWb(mq[k].tag, $urandom_range(16'hFFFF),
                ($urandom_range(99) < 10) ? !mq[k].pred : mq[k].pred);
      end
      step();
    end
    for (int n = 0; n < 200 && mq.size() > 0; n++) begin
      foreach (mq[k])
        if (!mq[k].done && !wbValid) setWb(mq[k].tag, 16'h0C00 + n, mq[k].pred);
      step();
    end
    chk("R5", "drained", mq.size(), 0);
    chkRegs("R5");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule